// File: doc/BRIEF.md
# Contiguous Resource Region Allocator

This block keeps the allocation state of a fixed pool of equal-sized slots. A slot can stand for a scalar register, a vector register or a unit of shared local memory. Every slot is in one of four states. The life of a slot begins at free. It can then be marked as a candidate while a reservation is being worked out. It is reserved once its work-group is mapped but before any wavefront has been dispatched. It is used while it is in active service.

A controller sends one command at a time on a valid/ready handshake. There are four commands:

- **Find** scans the pool one slot per clock. It looks for the lowest-offset run of consecutive slots that are all in a requested state.
- **Set** writes a state over an offset/length window.
- **Convert** moves every slot in one state to another state.
- **Count** reports how many slots are in a given state.

Each command ends with a one-cycle done pulse, and the response fields are valid in that cycle.

Top module: `region_alloc`

## Requirements
- R1: States are encoded free=2'b00, candidate=2'b01, reserved=2'b10, used=2'b11, and every slot is free after reset.
- R2: Find (cmd_op=2'b00) with length L and state S reports found=1 and the lowest offset O such that slots O..O+L-1 are all in S.
- R3: Find reports found=0 with offset 0 when no run qualifies, when L is zero, or when L exceeds the pool size.
- R4: Set (cmd_op=2'b01) writes cmd_state_a to every slot from cmd_offset up to, but not including, cmd_offset+cmd_length. All other slots keep their state.
- R5: A set whose end point passes the pool size is refused: rsp_error is 1 in its done cycle and no slot changes.
- R6: Convert (cmd_op=2'b10) moves every slot in cmd_state_a to cmd_state_b. Slots in any other state are left alone.
- R7: Count (cmd_op=2'b11) returns the number of slots in cmd_state_a, taken before any later command.
- R8: Set, convert and count raise rsp_done in the cycle right after acceptance. While a find is in progress cmd_ready stays low until its done.
- R9: A find raises rsp_done no more than SLOTS+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 00 find, 01 set, 10 convert, 11 count |
| cmd_offset | input | $clog2(SLOTS) | Start slot for set |
| cmd_length | input | $clog2(SLOTS+1) | Run length for find or set |
| cmd_state_a | input | 2 | Searched, written, source or counted state |
| cmd_state_b | input | 2 | Destination state for convert |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_found | output | 1 | Find located a run |
| rsp_offset | output | $clog2(SLOTS) | Start of the located run |
| rsp_count | output | $clog2(SLOTS+1) | Count result |
| rsp_error | output | 1 | Set refused for range overflow |

## Verification
The bench targets several corner cases.

- **Runs that end on the last slot.** A scanner that stops one slot early would report these as not found.
- **Runs that begin just after a non-matching slot.** An offset computed wrongly would come out shifted by one.
- **Lengths of zero, of the whole pool and of more than the pool.** A wrapped comparison would make these report found.
- **Set windows that end exactly at the pool boundary or one slot past it.** An off-by-one bound would either refuse a legal write or corrupt slots on an illegal one. The bench shows this through later counts.
- **Convert with equal source and destination states, and count after bulk changes.** A wrong mask would alter slots in unrelated states.

// File: rtl/region_alloc.sv
module region_alloc #(
  parameter int SLOTS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(SLOTS)-1:0]   cmd_offset,
  input  logic [$clog2(SLOTS+1)-1:0] cmd_length,
  input  logic [1:0]                 cmd_state_a,
  input  logic [1:0]                 cmd_state_b,
  output logic                       rsp_done,
  output logic                       rsp_found,
  output logic [$clog2(SLOTS)-1:0]   rsp_offset,
  output logic [$clog2(SLOTS+1)-1:0] rsp_count,
  output logic                       rsp_error
);
  localparam int OW = $clog2(SLOTS);
  localparam int LW = $clog2(SLOTS + 1);
  localparam int XW = LW + 1;
  localparam logic [1:0] OP_FIND = 2'b00, OP_SET = 2'b01, OP_CONV = 2'b10, OP_CNT = 2'b11;

  logic [2*SLOTS-1:0] slot_q, slot_d;
  logic               busy_q;
  logic [1:0]         sa_q;
  logic [LW-1:0]      len_q, run_q;
  logic [OW-1:0]      idx_q;

  function automatic logic [LW-1:0] tally(input logic [2*SLOTS-1:0] v, input logic [1:0] s);
    logic [LW-1:0] n;
    n = '0;
    for (int i = 0; i < SLOTS; i++)
      if (v[2*i +: 2] == s) n = n + LW'(1);
    return n;
  endfunction

  wire           accept  = cmd_valid & cmd_ready;
  wire  [XW-1:0] set_end = XW'(cmd_offset) + XW'(cmd_length);
  wire           set_bad = set_end > XW'(SLOTS);
  wire           len_bad = (cmd_length == '0) || (cmd_length > LW'(SLOTS));
  wire  [1:0]    cur     = slot_q[2*idx_q +: 2];
  wire           hit     = cur == sa_q;
  wire  [LW-1:0] run_nx  = hit ? run_q + LW'(1) : '0;
  wire           last    = idx_q == OW'(SLOTS - 1);
  wire  [XW-1:0] start_w = XW'(idx_q) + XW'(1) - XW'(len_q);

  assign cmd_ready = !busy_q;

  always_comb begin
    slot_d = slot_q;
    for (int i = 0; i < SLOTS; i++) begin
      if (accept && cmd_op == OP_SET && !set_bad &&
          XW'(i) >= XW'(cmd_offset) && XW'(i) < set_end)
        slot_d[2*i +: 2] = cmd_state_a;
      if (accept && cmd_op == OP_CONV && slot_q[2*i +: 2] == cmd_state_a)
        slot_d[2*i +: 2] = cmd_state_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q     <= '0;
      busy_q     <= 1'b0;
      sa_q       <= '0;
      len_q      <= '0;
      run_q      <= '0;
      idx_q      <= '0;
      rsp_done   <= 1'b0;
      rsp_found  <= 1'b0;
      rsp_offset <= '0;
      rsp_count  <= '0;
      rsp_error  <= 1'b0;
    end else begin
      slot_q   <= slot_d;
      rsp_done <= 1'b0;
      if (accept) begin
        sa_q  <= cmd_state_a;
        len_q <= cmd_length;
        if (cmd_op == OP_FIND && !len_bad) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          run_q  <= '0;
        end else begin
          rsp_done   <= 1'b1;
          rsp_found  <= 1'b0;
          rsp_offset <= '0;
          rsp_error  <= (cmd_op == OP_SET) && set_bad;
          rsp_count  <= (cmd_op == OP_CNT) ? tally(slot_q, cmd_state_a) : '0;
        end
      end else if (busy_q) begin
        if (hit && run_nx == len_q) begin
          busy_q     <= 1'b0;
          rsp_done   <= 1'b1;
          rsp_found  <= 1'b1;
          rsp_offset <= start_w[OW-1:0];
          rsp_count  <= '0;
          rsp_error  <= 1'b0;
        end else if (last) begin
          busy_q     <= 1'b0;
          rsp_done   <= 1'b1;
          rsp_found  <= 1'b0;
          rsp_offset <= '0;
          rsp_count  <= '0;
          rsp_error  <= 1'b0;
        end else begin
          idx_q <= idx_q + OW'(1);
          run_q <= run_nx;
        end
      end
    end
  end

  p_fit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_found |-> XW'(rsp_offset) + XW'(len_q) <= XW'(SLOTS));
  p_nf_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !rsp_found |-> rsp_offset == '0);
  p_err_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_SET && set_bad |=> rsp_error && slot_q == $past(slot_q));
  p_conv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_CONV && cmd_state_a != cmd_state_b |=> tally(slot_q, $past(cmd_state_a)) == '0);
  p_cnt_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_count <= LW'(SLOTS));
  p_quick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op != OP_FIND |=> rsp_done);
endmodule

// File: tb/sim_region_alloc.sv
module sim_region_alloc;
  localparam int N  = 64;
  localparam int OW = $clog2(N);
  localparam int LW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic cmd_ready, rsp_done, rsp_found, rsp_error;
  logic [1:0] cmd_op = 0, cmd_state_a = 0, cmd_state_b = 0;
  logic [OW-1:0] cmd_offset = 0, rsp_offset;
  logic [LW-1:0] cmd_length = 0, rsp_count;

  region_alloc #(.SLOTS(N)) u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit ended = 0;
  logic [1:0] m [N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mcount(input logic [1:0] s);
    int n = 0;
    for (int i = 0; i < N; i++) if (m[i] == s) n++;
    return n;
  endfunction

  function automatic int mfind(input int len, input logic [1:0] s);
    if (len == 0 || len > N) return -1;
    for (int o = 0; o + len <= N; o++) begin
      bit ok = 1;
      for (int j = 0; j < len; j++) if (m[o+j] != s) ok = 0;
      if (ok) return o;
    end
    return -1;
  endfunction

  task automatic run(input logic [1:0] op, input int off, input int len,
                     input logic [1:0] a, input logic [1:0] b);
    int w = 0;
    int exp;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_offset = OW'(off); cmd_length = LW'(len);
    cmd_state_a = a; cmd_state_b = b;
    @(negedge clk);
    cmd_valid = 0;
    w = 1;
    while (!rsp_done && w < N + 4) begin
      if (op == 2'b00) chk(!cmd_ready, "R8 ready low during find", int'(cmd_ready), 0);
      @(negedge clk);
      w++;
    end
    case (op)
      2'b00: begin
        exp = mfind(len, a);
        chk(w <= N + 1, "R9 find latency", w, N + 1);
        chk(rsp_found == (exp >= 0), exp >= 0 ? "R2 found flag" : "R3 found flag", int'(rsp_found), int'(exp >= 0));
        chk(int'(rsp_offset) == (exp >= 0 ? exp : 0), exp >= 0 ? "R2 offset" : "R3 offset", int'(rsp_offset), exp >= 0 ? exp : 0);
      end
      2'b01: begin
        chk(w == 1, "R8 set done timing", w, 1);
        chk(rsp_error == (off + len > N), "R5 error flag", int'(rsp_error), int'(off + len > N));
        if (off + len <= N) for (int i = off; i < off + len; i++) m[i] = a;
      end
      2'b10: begin
        chk(w == 1, "R8 convert done timing", w, 1);
        for (int i = 0; i < N; i++) if (m[i] == a) m[i] = b;
      end
      default: begin
        chk(w == 1, "R8 count done timing", w, 1);
        chk(int'(rsp_count) == mcount(a), "R7 count", int'(rsp_count), mcount(a));
      end
    endcase
  endtask

  task automatic audit(input string req);
    for (int s = 0; s < 4; s++) begin
      run(2'b11, 0, 0, 2'(s), 2'b00);
      chk(int'(rsp_count) == mcount(2'(s)), req, int'(rsp_count), mcount(2'(s)));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) m[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !rsp_done, "R1 idle after reset", int'(cmd_ready), 1);
    run(2'b11, 0, 0, 2'b00, 2'b00);
    chk(int'(rsp_count) == N, "R1 all free after reset", int'(rsp_count), N);
    run(2'b00, 0, 0, 2'b00, 2'b00);
    run(2'b00, 0, N + 1, 2'b00, 2'b00);
    run(2'b00, 0, N, 2'b00, 2'b00);
    run(2'b01, 60, 4, 2'b11, 2'b00);
    audit("R4 window up to pool end");
    run(2'b01, 62, 4, 2'b10, 2'b00);
    audit("R5 refused set leaves slots");
    run(2'b00, 0, 4, 2'b11, 2'b00);
    run(2'b01, 10, 1, 2'b01, 2'b00);
    run(2'b00, 0, 20, 2'b00, 2'b00);
    run(2'b01, 0, 0, 2'b10, 2'b00);
    audit("R4 zero length writes nothing");
    run(2'b10, 0, 0, 2'b11, 2'b11);
    audit("R6 convert to same state");
    run(2'b10, 0, 0, 2'b11, 2'b10);
    audit("R6 convert moves only source");
    run(2'b01, 0, N, 2'b11, 2'b00);
    run(2'b00, 0, 1, 2'b00, 2'b00);
    run(2'b00, 0, N, 2'b11, 2'b00);
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 3);
      int off = $urandom_range(0, N - 1);
      int len = ($urandom_range(0, 7) == 0) ? $urandom_range(0, N + 1) : $urandom_range(1, 8);
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [1:0] b = 2'($urandom_range(0, 3));
      run(2'(op), off, len, a, b);
    end
    audit("R4 R6 final state");
    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule